// File: doc/BRIEF.md
# Sequential Digit-Stop Capture Controller

This block runs a "stop the digit" game on a four-digit numeric display. A counter cycles through the decimal digits 1 to 9 without stopping. One stop button freezes the three playable display slots one after another. Each accepted press copies the counter's current value into the next slot that is not yet frozen. Slots frozen earlier keep their digits. Slots not yet frozen show the live counter, so they appear to spin.

The result is a 16-bit word of four 4-bit nibbles for an external seven-segment decoder and multiplexer. The top nibble carries a constant set at build time. A restart input clears the game so that play begins again at the first slot. Both the stop button and the restart input may be asynchronous to the clock. Each passes through a synchronizer and a debouncer inside the block.

Top module: `digit_stop_ctrl`

## Requirements
- R1: The live digit starts at 1 and moves on by one every TICK_DIV clock cycles. It runs through the values 1 to 9 and wraps from 9 back to 1. After reset or restart it holds 1 for the first TICK_DIV cycles.
- R2: `disp_o[15:12]` always equals FIXED_DIGIT. Slot 0 drives `disp_o[11:8]`, slot 1 drives `disp_o[7:4]` and slot 2 drives `disp_o[3:0]`. A slot that is not frozen shows the live digit.
- R3: Each accepted press freezes the lowest-numbered unfrozen slot, so the order is `[11:8]`, then `[7:4]`, then `[3:0]`. The frozen value is the live digit shown in the cycle just before the freeze.
- R4: A frozen slot keeps its digit, whatever the counter and later presses do, until restart or reset.
- R5: Once all three slots are frozen, further presses change nothing until a restart.
- R6: While the conditioned restart level is high, the counter and all three captures hold 1 and no slot is frozen. Presses made during that time are ignored. After restart is released, the next press freezes `[11:8]`, and the counter resumes as after reset.
- R7: An input change is accepted only after the synchronized input has differed from the accepted level for DEBOUNCE_CYCLES consecutive cycles. Pulses shorter than that are ignored. A press held for any length of time freezes exactly one slot.
- R8: A raw button rise sampled on edge E freezes its slot on edge E+DEBOUNCE_CYCLES+2. Release of restart follows the same latency.
- R9: While `rst_n` is low, the output reads FIXED_DIGIT followed by three nibbles of 1, and no slot is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_btn_i | input | 1 | Raw stop button, active high, may bounce |
| restart_i | input | 1 | Raw restart level, active high, may be asynchronous |
| disp_o | output | 16 | Four display nibbles; top nibble is the constant |

## Verification
The assertions assume that `rst_n` is applied before any other activity. They also assume that the raw inputs change at most once per clock period, so that the two-stage synchronizers always present a settled level to the debouncers. The bench drives both raw inputs only on falling clock edges. It holds every intended press or release for several cycles longer than the debounce window. It makes glitches exactly one cycle shorter than the window, so each stimulus is either clearly accepted or clearly rejected. Reset is released on a falling edge, so no property samples a half-reset state.

// File: rtl/dstop_pkg.sv
package dstop_pkg;
  localparam int DIGIT_W = 4;
  localparam int SLOTS   = 3;
  localparam logic [DIGIT_W-1:0] DIGIT_LO = 4'd1;
  localparam logic [DIGIT_W-1:0] DIGIT_HI = 4'd9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    FZ_NONE = 2'd0,
    FZ_ONE  = 2'd1,
    FZ_TWO  = 2'd2,
    FZ_ALL  = 2'd3
  } frz_state_t;

  // Successor of a decimal digit in the 1..9 loop.
  function automatic digit_t digit_succ(digit_t d);
    if (d >= DIGIT_HI) return DIGIT_LO;
    return d + digit_t'(1);
  endfunction

  // Which slots are frozen in a given state; bit 0 is the first slot.
  function automatic logic [SLOTS-1:0] frozen_of(frz_state_t s);
    case (s)
      FZ_NONE: return 3'b000;
      FZ_ONE:  return 3'b001;
      FZ_TWO:  return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  // One-hot pointer to the slot the next press fills; zero when full.
  function automatic logic [SLOTS-1:0] target_of(frz_state_t s);
    case (s)
      FZ_NONE: return 3'b001;
      FZ_ONE:  return 3'b010;
      FZ_TWO:  return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  function automatic frz_state_t frz_advance(frz_state_t s);
    case (s)
      FZ_NONE: return FZ_ONE;
      FZ_ONE:  return FZ_TWO;
      default: return FZ_ALL;
    endcase
  endfunction
endpackage

// File: rtl/dstop_debounce.sv
module dstop_debounce #(
  parameter int STABLE_CYCLES = 4,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o
);
  localparam int CW = (STABLE_CYCLES > 1) ? $clog2(STABLE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CW-1:0]          run_q;
  logic                   level_q;
  logic                   level_d;
  logic                   differs;
  logic                   accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
  end

  assign synced  = sync_q[SYNC_STAGES-1];
  assign differs = synced != level_q;
  assign accept  = differs && (run_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b0;
      level_d <= 1'b0;
    end else begin
      level_d <= level_q;
      if (accept) begin
        level_q <= synced;
        run_q   <= '0;
      end else if (differs) begin
        run_q <= run_q + CW'(1);
      end else begin
        run_q <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~level_d;

  // R7
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

  // R7
  level_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(level_q) |-> $past(synced));

  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !differs |=> $stable(level_q));
endmodule

// File: rtl/dstop_digit_counter.sv
module dstop_digit_counter
  import dstop_pkg::*;
#(
  parameter int TICK_DIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_i,
  output digit_t digit_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  digit_t        digit_q;
  logic          step;

  assign step = (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      digit_q <= DIGIT_LO;
    end else if (clr_i) begin
      pre_q   <= '0;
      digit_q <= DIGIT_LO;
    end else if (step) begin
      pre_q   <= '0;
      digit_q <= digit_succ(digit_q);
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  assign digit_o = digit_q;

  // R1
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (digit_q >= DIGIT_LO) && (digit_q <= DIGIT_HI));

  // R1
  digit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr_i) |=> $stable(digit_q));

  // R1
  digit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr_i && digit_q == DIGIT_HI) |=> (digit_q == DIGIT_LO));
endmodule

// File: rtl/dstop_capture_bank.sv
module dstop_capture_bank
  import dstop_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          press_i,
  input  digit_t                        live_i,
  output logic [SLOTS-1:0]              frozen_o,
  output logic [SLOTS-1:0][DIGIT_W-1:0] cap_o
);
  frz_state_t                    state_q;
  frz_state_t                    state_d;
  logic [SLOTS-1:0]              target;
  logic [SLOTS-1:0]              load_ev;
  logic [SLOTS-1:0]              frz_mask;
  logic [SLOTS-1:0][DIGIT_W-1:0] cap_q;

  assign target   = target_of(state_q);
  assign frz_mask = frozen_of(state_q);
  assign load_ev  = (press_i && !clr_i) ? target : '0;

  always_comb begin
    state_d = state_q;
    if (clr_i)        state_d = FZ_NONE;
    else if (press_i) state_d = frz_advance(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FZ_NONE;
    else        state_q <= state_d;
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cap_q[g] <= DIGIT_LO;
      else if (clr_i)      cap_q[g] <= DIGIT_LO;
      else if (load_ev[g]) cap_q[g] <= live_i;
    end

    // R4
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_mask[g] && !clr_i) |=> $stable(cap_q[g]));

    // R6
    clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cap_q[g] == DIGIT_LO));
  end

  assign frozen_o = frz_mask;
  assign cap_o    = cap_q;

  // R3
  one_slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ($countones(frz_mask) <= $countones($past(frz_mask)) + 1));

  // R3
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_ev));

  // R5
  full_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == FZ_ALL && !clr_i) |=> (state_q == FZ_ALL));

  // R6
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (frz_mask == '0));
endmodule

// File: rtl/digit_stop_ctrl.sv
module digit_stop_ctrl
  import dstop_pkg::*;
#(
  parameter int          DEBOUNCE_CYCLES = 500000,
  parameter int          TICK_DIV        = 5000000,
  parameter logic [3:0]  FIXED_DIGIT     = 4'hC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stop_btn_i,
  input  logic        restart_i,
  output logic [15:0] disp_o
);
  localparam int DISP_W = (SLOTS + 1) * DIGIT_W;

  logic                          btn_level;
  logic                          btn_rise;
  logic                          rst_level;
  logic                          rst_rise;
  digit_t                        live_digit;
  logic [SLOTS-1:0]              frozen;
  logic [SLOTS-1:0][DIGIT_W-1:0] cap;
  logic [DISP_W-1:0]             disp_w;

  dstop_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES), .SYNC_STAGES(2)) u_btn_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (stop_btn_i),
    .level_o (btn_level),
    .rise_o  (btn_rise)
  );

  dstop_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES), .SYNC_STAGES(2)) u_rst_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (restart_i),
    .level_o (rst_level),
    .rise_o  (rst_rise)
  );

  dstop_digit_counter #(.TICK_DIV(TICK_DIV)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (rst_level),
    .digit_o (live_digit)
  );

  dstop_capture_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (rst_level),
    .press_i  (btn_rise),
    .live_i   (live_digit),
    .frozen_o (frozen),
    .cap_o    (cap)
  );

  assign disp_w[DISP_W-1 -: DIGIT_W] = FIXED_DIGIT;
  for (genvar s = 0; s < SLOTS; s++) begin : g_disp
    assign disp_w[(SLOTS-1-s)*DIGIT_W +: DIGIT_W] = frozen[s] ? cap[s] : live_digit;
  end

  assign disp_o = disp_w;

  // R7
  press_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |-> btn_level);

  // R6
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_rise |=> (disp_o[11:0] == 12'h111));

  // R2
  fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(disp_o[15:12]));
endmodule

// File: tb/test_digit_stop_ctrl.sv
module test_digit_stop_ctrl;
  localparam int         DB  = 3;
  localparam int         TD  = 2;
  localparam logic [3:0] FIX = 4'hC;
  localparam int         NV  = 12;
  // Vector: {op[1:0], expected frozen mask[2:0]}; mask bit0 = [11:8].
  // op 0 = press, 1 = short glitch, 2 = restart, 3 = press held during restart.
  localparam logic [4:0] VEC [NV] = '{
    {2'd0, 3'b001}, {2'd1, 3'b001}, {2'd0, 3'b011}, {2'd0, 3'b111},
    {2'd0, 3'b111}, {2'd2, 3'b000}, {2'd0, 3'b001}, {2'd1, 3'b001},
    {2'd3, 3'b000}, {2'd0, 3'b001}, {2'd0, 3'b011}, {2'd0, 3'b111}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        btn = 1'b0;
  logic        rsti = 1'b0;
  logic [15:0] disp;

  int checks = 0;
  int errors = 0;
  int nfrz   = 0;
  logic [3:0] exp_cap [3];

  always #10 clk = ~clk;

  digit_stop_ctrl #(.DEBOUNCE_CYCLES(DB), .TICK_DIV(TD), .FIXED_DIGIT(FIX)) i_digit_stop_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_btn_i (btn),
    .restart_i  (rsti),
    .disp_o     (disp)
  );

  function automatic logic [3:0] slot_nib(int s);
    return 4'((disp >> ((2 - s) * 4)) & 16'h000F);
  endfunction

  function automatic logic [3:0] model_digit(int k);
    return 4'(((k / TD) % 9) + 1);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Live slot 0 follows the digit sequence from a fresh start (k = 0 now).
  task automatic check_sequence(input string req);
    for (int k = 0; k < 2 * 9 * TD; k++) begin
      check(req, {12'h0, slot_nib(0)}, {12'h0, model_digit(k)});
      @(negedge clk);
    end
  endtask

  task automatic press();
    int   s;
    logic take;
    s = nfrz;
    take = (nfrz < 3);
    @(negedge clk) btn = 1'b1;
    repeat (DB + 2) @(posedge clk);
    @(negedge clk);
    if (take) exp_cap[s] = slot_nib(s);   // R8: value shown just before the freeze edge
    repeat (DB + 6) @(negedge clk);
    btn = 1'b0;
    repeat (DB + 6) @(negedge clk);
    if (take) begin
      nfrz++;
      check("R3 captured digit", {12'h0, slot_nib(s)}, {12'h0, exp_cap[s]});
    end
  endtask

  task automatic glitch();
    @(negedge clk) btn = 1'b1;
    repeat (DB - 1) @(negedge clk);
    btn = 1'b0;
    repeat (DB + 6) @(negedge clk);
  endtask

  task automatic restart(input logic with_press);
    @(negedge clk) rsti = 1'b1;
    repeat (DB + 6) @(negedge clk);
    check("R6 display held during restart", disp, {FIX, 12'h111});
    if (with_press) begin
      btn = 1'b1;
      repeat (DB + 6) @(negedge clk);
      btn = 1'b0;
      repeat (DB + 6) @(negedge clk);
      check("R6 press ignored during restart", disp, {FIX, 12'h111});
    end
    rsti = 1'b0;
    repeat (DB + 2) @(posedge clk);
    @(negedge clk);
    nfrz = 0;
    for (int i = 0; i < 3; i++) exp_cap[i] = 4'd1;
    check_sequence("R6 counter restarts after release");
  endtask

  // Watch all slots long enough for a live slot to change at least once.
  task automatic observe(input logic [2:0] exp_mask, input int vi);
    logic [3:0] first [3];
    logic [2:0] moved;
    logic       top_ok;
    moved = '0;
    top_ok = 1'b1;
    for (int s = 0; s < 3; s++) first[s] = slot_nib(s);
    for (int c = 0; c < 9 * TD + 4; c++) begin
      @(negedge clk);
      for (int s = 0; s < 3; s++) if (slot_nib(s) != first[s]) moved[s] = 1'b1;
      if (disp[15:12] !== FIX) top_ok = 1'b0;
    end
    check($sformatf("R2 fixed top nibble, vector %0d", vi), {15'h0, top_ok}, 16'h1);
    for (int s = 0; s < 3; s++) begin
      if (exp_mask[s]) begin
        check($sformatf("R4 slot %0d frozen, vector %0d", s, vi), {15'h0, moved[s]}, 16'h0);
        check($sformatf("R4 slot %0d value, vector %0d", s, vi),
              {12'h0, slot_nib(s)}, {12'h0, exp_cap[s]});
      end else begin
        check($sformatf("R2 slot %0d live, vector %0d", s, vi), {15'h0, moved[s]}, 16'h1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) exp_cap[i] = 4'd1;
    repeat (3) @(negedge clk);
    check("R9 reset value", disp, {FIX, 12'h111});
    rst_n = 1'b1;
    check_sequence("R1 digit sequence after reset");

    for (int v = 0; v < NV; v++) begin
      case (VEC[v][4:3])
        2'd0: press();
        2'd1: glitch();      // R7: shorter than the debounce window
        2'd2: restart(1'b0);
        default: restart(1'b1);
      endcase
      observe(VEC[v][2:0], v);
    end

    // R5: with all slots frozen, the frozen word does not move.
    begin
      logic [15:0] held;
      held = disp;
      press();
      check("R5 press after all frozen", disp, held);
    end

    // R7: a long hold freezes exactly one slot.
    restart(1'b0);
    @(negedge clk) btn = 1'b1;
    repeat (DB + 2) @(posedge clk);
    @(negedge clk);
    exp_cap[0] = slot_nib(0);
    repeat (40) @(negedge clk);
    btn = 1'b0;
    repeat (DB + 6) @(negedge clk);
    nfrz = 1;
    observe(3'b001, 99);
    check("R7 long hold freezes one slot", {12'h0, slot_nib(0)}, {12'h0, exp_cap[0]});

    // R9: reset in mid game.
    press();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset in mid game", disp, {FIX, 12'h111});
    rst_n = 1'b1;
    nfrz = 0;
    for (int i = 0; i < 3; i++) exp_cap[i] = 4'd1;
    observe(3'b000, 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule